// File: doc/BRIEF.md
# Single-Mode SAR Conversion Controller

This block runs one successive-approximation analog-to-digital channel in single mode. Software writes a small control register that picks a start source and a completion route, and can start or abort a conversion. A conversion starts either from a register write or from a rising edge on one of four hardware trigger lines. The successive-approximation code is driven out to an external DAC. A one-bit comparator answer comes back. The block settles one bit per clock, from the most significant bit down, and then copies the finished code into a result register.

On normal completion the block raises a one-cycle pulse on the interrupt output or on the DMA output, as the register selects. An abort halts the sequence at once. The partial code stays visible on the approximation output, the result register keeps its old value, no request is raised, and the completion flag reads 1 again. A scan-mode input parks the controller: starts, triggers and aborts are not acted on while it is high. No stream interface crosses the block edge. The result register holds its value until the next completed conversion replaces it, so nothing can back-pressure it.

Top module: `adc_single_ctrl`

## Requirements
- R1: After reset, ctrl_rd reads 7'h40 (completion flag, bit 6, is 1), result and sar_code are 0, and both request outputs are low.
- R2: A write with wr_data bit 4 (start) = 1 and bit 2 (hardware select) = 0, made while idle and not in scan mode, starts a conversion. From the next cycle the completion flag reads 0 and sar_code reads 10'h200.
- R3: The code is settled one bit per clock, MSB first. After k settling cycles (k < 10) sar_code holds the top k bits of the answer, with bit 9-k set and the lower bits 0. With cmp_hi = 1 meaning the analog input is at or above sar_code, result equals the analog value 11 cycles after the start edge, and the completion flag returns to 1 in the same cycle.
- R4: On normal completion exactly one request output pulses for one cycle: irq_req when wr_data bit 3 was last written 0, dma_req when it was written 1. They are never high together.
- R5: When the hardware select bit is 1, a rising edge on trig_in[sel] starts a conversion. sel is wr_data[1:0] (0 timer underflow, 1 external pin, 2 timer enable event, 3 companion converter done). Edges on the other lines, and software start writes, start nothing.
- R6: When the hardware select bit is 0, trigger edges start nothing.
- R7: Start writes and trigger edges that arrive during a running conversion are ignored; the result and the completion timing are unchanged.
- R8: A write with wr_data bit 5 (stop) = 1 during a running conversion halts it at that edge. The completion flag reads 1, sar_code keeps its partial value, result is unchanged, and no request is issued.
- R9: Stop writes have no effect while idle or while scan_mode is 1; in scan mode a running conversion completes normally.
- R10: While scan_mode is 1, start writes and trigger edges start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_mode | input | 1 | 1 selects scan mode; this block then stays idle |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 6 | [1:0] trigger select, [2] hardware start, [3] DMA route, [4] start, [5] stop |
| trig_in | input | 4 | Hardware trigger lines, rising-edge sensitive |
| cmp_hi | input | 1 | Comparator: 1 when analog input >= sar_code |
| ctrl_rd | output | 7 | Readback: [3:0] stored config, [5:4] zero, [6] completion flag |
| sar_code | output | 10 | Successive-approximation code driven to the DAC |
| result | output | 10 | Data register holding the last completed conversion |
| irq_req | output | 1 | One-cycle interrupt request on completion |
| dma_req | output | 1 | One-cycle DMA request on completion |

## Verification
The bench sweeps all 1024 analog values through full conversions with both request routes, so a wrong bit order or a misplaced comparator test shows up as a wrong result or a late flag. It aborts at every settling position, including the final transfer cycle, and compares the frozen partial code with the arithmetic prefix. A design that let the transfer run would overwrite the result or raise a request. Each trigger select is crossed with each trigger line, and retriggers and restarts are sent mid-conversion. A faulty select decoder starts on the wrong line, and a controller that can be re-armed returns the wrong code. Stop writes are also sent while idle and in scan mode; a design that acts on them clears the flag or disturbs the code.

// File: rtl/adc_sm_pkg.sv
package adc_sm_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_XFER = 2'd2
  } seq_st_t;
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs #(
  parameter int unsigned TSEL_W = 2,
  localparam int unsigned CW = TSEL_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_mode,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_data,
  output logic [TSEL_W-1:0] trig_sel,
  output logic              hw_sel,
  output logic              dma_sel,
  output logic              sw_go,
  output logic              halt_go
);
  localparam int unsigned HB = TSEL_W;
  localparam int unsigned DB = TSEL_W + 1;
  localparam int unsigned GB = TSEL_W + 2;
  localparam int unsigned SB = TSEL_W + 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_sel <= '0;
      hw_sel   <= 1'b0;
      dma_sel  <= 1'b0;
    end else if (wr_en) begin
      trig_sel <= wr_data[TSEL_W-1:0];
      hw_sel   <= wr_data[HB];
      dma_sel  <= wr_data[DB];
    end
  end

  // a software start counts only if the same write selects software starting
  always_comb begin
    sw_go   = wr_en && wr_data[GB] && !wr_data[HB] && !scan_mode;
    halt_go = wr_en && wr_data[SB] && !scan_mode;
  end
endmodule

// File: rtl/adc_trig_pick.sv
module adc_trig_pick #(
  parameter int unsigned N_TRIG = 4,
  localparam int unsigned TSEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [TSEL_W-1:0] trig_sel,
  input  logic              hw_sel,
  input  logic              scan_mode,
  output logic              hw_go
);
  logic [N_TRIG-1:0] rise;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_line
    logic last_q;
    always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= trig_in[g];
    end
    assign rise[g] = trig_in[g] && !last_q;
  end

  always_comb hw_go = hw_sel && !scan_mode && rise[trig_sel];
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_sm_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  localparam int unsigned IW = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] sar_q,
  output logic [RES_W-1:0] result_q,
  output logic             done_q,
  output logic             fin
);
  seq_st_t        st_q;
  logic [IW-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SEQ_IDLE;
      idx_q    <= '0;
      sar_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b1;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          if (go) begin
            sar_q  <= {1'b1, {(RES_W-1){1'b0}}};
            idx_q  <= IW'(RES_W - 1);
            done_q <= 1'b0;
            st_q   <= SEQ_CONV;
          end
        end
        SEQ_CONV: begin
          if (halt) begin
            done_q <= 1'b1;
            st_q   <= SEQ_IDLE;
          end else begin
            sar_q[idx_q] <= cmp_hi;
            if (idx_q != '0) sar_q[idx_q - IW'(1)] <= 1'b1;
            else             st_q <= SEQ_XFER;
            idx_q <= idx_q - IW'(1);
          end
        end
        SEQ_XFER: begin
          if (!halt) result_q <= sar_q;
          done_q <= 1'b1;
          st_q   <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb fin = (st_q == SEQ_XFER) && !halt;
endmodule

// File: rtl/adc_single_ctrl.sv
module adc_single_ctrl #(
  parameter int unsigned N_TRIG = 4,
  parameter int unsigned RES_W  = 10,
  localparam int unsigned TSEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1,
  localparam int unsigned CW = TSEL_W + 4,
  localparam int unsigned RW = TSEL_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_mode,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_data,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic              cmp_hi,
  output logic [RW-1:0]     ctrl_rd,
  output logic [RES_W-1:0]  sar_code,
  output logic [RES_W-1:0]  result,
  output logic              irq_req,
  output logic              dma_req
);
  logic [TSEL_W-1:0] trig_sel;
  logic hw_sel, dma_sel, sw_go, halt_go, hw_go, done, fin;

  adc_ctrl_regs #(.TSEL_W(TSEL_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .wr_en(wr_en),
    .wr_data(wr_data), .trig_sel(trig_sel), .hw_sel(hw_sel),
    .dma_sel(dma_sel), .sw_go(sw_go), .halt_go(halt_go)
  );

  adc_trig_pick #(.N_TRIG(N_TRIG)) i_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel),
    .hw_sel(hw_sel), .scan_mode(scan_mode), .hw_go(hw_go)
  );

  adc_sar_seq #(.RES_W(RES_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .go(sw_go || hw_go), .halt(halt_go),
    .cmp_hi(cmp_hi), .sar_q(sar_code), .result_q(result), .done_q(done),
    .fin(fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      irq_req <= fin && !dma_sel;
      dma_req <= fin && dma_sel;
    end
  end

  always_comb ctrl_rd = {done, 2'b00, dma_sel, hw_sel, trig_sel};
endmodule

// File: rtl/adc_single_ctrl_chk.sv
module adc_single_ctrl_chk #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_mode,
  input logic             wr_en,
  input logic             wr_hw_b,
  input logic             wr_go_b,
  input logic             wr_halt_b,
  input logic             done_bit,
  input logic [RES_W-1:0] sar_code,
  input logic [RES_W-1:0] result,
  input logic             irq_req,
  input logic             dma_req
);
  p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req && dma_req));

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || dma_req) |=> !(irq_req || dma_req));

  p_req_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || dma_req) |-> done_bit);

  p_result_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (irq_req || dma_req));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_go_b && !wr_hw_b && !scan_mode && done_bit)
    |=> (!done_bit && sar_code == {1'b1, {(RES_W-1){1'b0}}}));

  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_halt_b && !scan_mode && !done_bit)
    |=> (done_bit && $stable(sar_code) && $stable(result) && !irq_req && !dma_req));

  p_idle_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_halt_b && !wr_go_b && wr_hw_b == 1'b0 && done_bit)
    |=> (done_bit && $stable(sar_code) && $stable(result)));

  p_scan_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode && done_bit) |=> done_bit);
endmodule

bind adc_single_ctrl adc_single_ctrl_chk #(.RES_W(RES_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .wr_en(wr_en),
  .wr_hw_b(wr_data[TSEL_W]), .wr_go_b(wr_data[TSEL_W+2]),
  .wr_halt_b(wr_data[TSEL_W+3]), .done_bit(ctrl_rd[TSEL_W+4]),
  .sar_code(sar_code), .result(result), .irq_req(irq_req), .dma_req(dma_req)
);

// File: tb/test_adc_single_ctrl.sv
module test_adc_single_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic [3:0] trig_in = '0;
  logic       cmp_hi;
  logic [6:0] ctrl_rd;
  logic [9:0] sar_code, result;
  logic       irq_req, dma_req;
  logic [9:0] ana = '0;
  logic [9:0] exp_res = '0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign cmp_hi = (ana >= sar_code);

  adc_single_ctrl i_adc_single_ctrl (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .wr_en(wr_en),
    .wr_data(wr_data), .trig_in(trig_in), .cmp_hi(cmp_hi), .ctrl_rd(ctrl_rd),
    .sar_code(sar_code), .result(result), .irq_req(irq_req), .dma_req(dma_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] cfg(input int sel, input bit hw, input bit dma,
                                     input bit go, input bit halt);
    return {halt, go, dma, hw, 2'(sel)};
  endfunction

  function automatic int partial(input int a, input int k);
    if (k >= 10) return a;
    return (a & ~((1 << (10 - k)) - 1)) | (1 << (9 - k));
  endfunction

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [5:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // entered just after the start edge
  task automatic finish(input string req, input int a, input bit dma);
    chk({req, " R2 busy flag"}, ctrl_rd[6], 0);
    chk({req, " R2 first trial"}, sar_code, 10'h200);
    repeat (10) @(negedge clk);
    chk({req, " R3 no early req"}, irq_req | dma_req, 0);
    chk({req, " R3 still busy"}, ctrl_rd[6], 0);
    @(negedge clk);
    chk({req, " R3 result"}, result, a);
    chk({req, " R3 flag set"}, ctrl_rd[6], 1);
    chk({req, " R4 irq"}, irq_req, !dma);
    chk({req, " R4 dma"}, dma_req, dma);
    @(negedge clk);
    chk({req, " R4 pulse ends"}, irq_req | dma_req, 0);
    exp_res = 10'(a);
  endtask

  // 12 cycles in which nothing may start or be requested
  task automatic quiet(input string req);
    logic [9:0] s = sar_code;
    bit bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (irq_req || dma_req || !ctrl_rd[6] || sar_code != s) bad = 1;
    end
    chk({req, " stays idle"}, bad, 0);
    chk({req, " result kept"}, result, exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl_rd", ctrl_rd, 7'h40);
    chk("R1 result", result, 0);
    chk("R1 sar", sar_code, 0);
    chk("R1 req", irq_req | dma_req, 0);

    // R3 exhaustive sweep with both routes
    for (int a = 0; a < 1024; a++) begin
      ana = 10'(a);
      wr(cfg(0, 0, a[0], 1, 0));
      finish("R3 sweep", a, a[0]);
    end

    // R8 abort at every settling position and in the transfer cycle
    for (int k = 0; k <= 10; k++) begin
      int a = (10'h2d6 + k * 37) & 10'h3ff;
      ana = 10'(a);
      wr(cfg(0, 0, 0, 1, 0));
      repeat (k) @(negedge clk);
      chk("R3 partial code", sar_code, partial(a, k));
      wr(cfg(0, 0, 0, 0, 1));
      chk("R8 flag set", ctrl_rd[6], 1);
      chk("R8 frozen code", sar_code, partial(a, k));
      quiet("R8 no transfer");
    end

    // R9 stop while idle
    wr(cfg(0, 0, 0, 0, 1));
    chk("R9 idle stop ctrl", ctrl_rd, 7'h40);
    quiet("R9 idle stop");

    // R9 stop in scan mode during a running conversion
    ana = 10'h155;
    wr(cfg(0, 0, 0, 1, 0));
    repeat (3) @(negedge clk);
    scan_mode = 1'b1;
    wr(cfg(0, 0, 0, 0, 1));
    chk("R9 scan stop ignored", ctrl_rd[6], 0);
    repeat (7) @(negedge clk);
    chk("R9 completes", result, 10'h155);
    chk("R9 req", irq_req, 1);
    exp_res = 10'h155;
    @(negedge clk);

    // R10 scan mode blocks starts and triggers
    wr(cfg(0, 0, 0, 1, 0));
    quiet("R10 sw start");
    wr(cfg(1, 1, 0, 0, 0));
    trig_in[1] = 1'b1; @(negedge clk); trig_in[1] = 1'b0;
    quiet("R10 trigger");
    scan_mode = 1'b0;
    @(negedge clk);

    // R5 every select against every line
    for (int sel = 0; sel < 4; sel++) begin
      for (int j = 0; j < 4; j++) begin
        bit dma = sel[0];
        ana = 10'(37 * (sel * 4 + j) + 11);
        wr(cfg(sel, 1, dma, 0, 0));
        trig_in[j] = 1'b1; @(negedge clk); trig_in[j] = 1'b0;
        if (j == sel) finish("R5 selected line", ana, dma);
        else quiet("R5 other line");
      end
    end
    wr(cfg(0, 1, 0, 1, 0));
    quiet("R5 sw start in hw mode");

    // R6 triggers with software start selected
    wr(cfg(2, 0, 0, 0, 0));
    trig_in = 4'hf; @(negedge clk); trig_in = 4'h0;
    quiet("R6 trigger in sw mode");

    // R7 restart write mid-conversion
    ana = 10'h3c3;
    wr(cfg(0, 0, 0, 1, 0));
    wr(cfg(0, 0, 0, 1, 0));
    repeat (9) @(negedge clk);
    chk("R7 sw still busy", ctrl_rd[6], 0);
    @(negedge clk);
    chk("R7 sw result", result, 10'h3c3);
    chk("R7 sw timing", irq_req, 1);
    exp_res = 10'h3c3;
    @(negedge clk);

    // R7 retrigger mid-conversion
    ana = 10'h0a5;
    wr(cfg(3, 1, 1, 0, 0));
    trig_in[3] = 1'b1; @(negedge clk); trig_in[3] = 1'b0;
    @(negedge clk);
    trig_in[3] = 1'b1; @(negedge clk); trig_in[3] = 1'b0;
    repeat (8) @(negedge clk);
    chk("R7 hw still busy", ctrl_rd[6], 0);
    @(negedge clk);
    chk("R7 hw result", result, 10'h0a5);
    chk("R7 hw timing", dma_req, 1);
    exp_res = 10'h0a5;
    quiet("R7 no second run");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule